// File: doc/BRIEF.md
# Gate-Drive Timeout Supervisor

This block watches the switching of several gate-driver channels. Each time a channel's PWM command changes level, a per-channel timer starts counting system clock cycles. The timer stops as soon as that channel's gate-voltage comparator shows the level the command asks for. If the programmed drive time runs out first, a gate fault is detected on that channel.

A 2-bit policy input decides what a detected fault does. The fault can latch a shutdown until software clears it. It can shut the channel down only until that channel's next rising PWM command. It can raise a warning and take no action. It can also be ignored. During a shutdown the affected channel's gate pull-down is enabled and its PWM command is blocked from its gate output. A one-cycle clear pulse removes the sticky status.

Top module: `gate_fault_monitor`

## Requirements
- R1: After synchronous reset every status output, every pull-down enable and every sticky bit is 0.
- R2: A fault is detected at the clock edge that samples the comparator still different from the commanded level for the (limit+1)-th time after the PWM edge. Here limit is `drive_time_i`. The status shows one edge after the PWM edge plus limit+1 further edges. If the comparator matches at any earlier sample, no fault is detected.
- R3: Every PWM edge, rising or falling, restarts the channel's timer from zero.
- R4: Policy `mode_i`=2'b00 (latched): a fault sets that channel's `pulldn_o` bit, `flt_o` and `chan_flt_o` bit. `gd_o` and `warn_o` stay 0.
- R5: In latched policy the shutdown and status stay set through later PWM edges and comparator changes. Only a `clr_flt_i` pulse removes them. A clear with no coincident fault zeroes all sticky bits and pull-downs.
- R6: Policy 2'b01 (cycle-by-cycle): a fault sets the channel's `pulldn_o` bit, `flt_o`, `gd_o` and the channel's `chan_flt_o` bit.
- R7: In cycle-by-cycle policy, the clock edge that samples the channel's next rising PWM command clears that channel's pull-down and, with it, `flt_o`. A falling command does not clear them. `gd_o` and `chan_flt_o` stay set until `clr_flt_i`.
- R8: Policy 2'b10 (warning): a fault sets `warn_o` and the channel's `chan_flt_o` bit. No pull-down is enabled, `flt_o` stays 0, and the gate output keeps following PWM. Both bits are held until `clr_flt_i`.
- R9: Policy 2'b11 (off): gate faults set no status bit and enable no pull-down.
- R10: When `clr_flt_i` and a new fault detection fall in the same cycle, the new fault is recorded and stays set.
- R11: `gate_o[i]` equals `pwm_i[i]` while `pulldn_o[i]` is 0, and is 0 while `pulldn_o[i]` is 1. `flt_o` is the OR of all `pulldn_o` bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwm_i | input | NCH | PWM command per channel |
| vgs_i | input | NCH | Gate-voltage comparator per channel, 1 = gate high |
| drive_time_i | input | TW | Drive-time limit in clock cycles |
| mode_i | input | 2 | Fault policy: 00 latched, 01 cycle-by-cycle, 10 warning, 11 off |
| clr_flt_i | input | 1 | One-cycle clear-fault pulse |
| gate_o | output | NCH | PWM passed to the gate drive, blocked during shutdown |
| pulldn_o | output | NCH | Gate pull-down enable per channel |
| flt_o | output | 1 | Global fault (any channel shut down) |
| warn_o | output | 1 | Sticky warning |
| gd_o | output | 1 | Sticky gate-driver summary (cycle-by-cycle faults) |
| chan_flt_o | output | NCH | Sticky gate-fault bit per channel |

## Verification
A fault becomes visible one clock edge after the edge that registers the PWM change plus limit+1 more edges. A clear or a qualifying rising edge acts on the single edge that samples it. `gate_o` and `flt_o` follow the registered shutdown state without further delay. Inputs are changed 1 ns after a rising edge, and outputs are read at that same point after each edge. Each boundary test therefore counts edges exactly: it checks one edge before the fault is due and again at the edge where it is due. A restart test moves that edge by re-triggering the command, and a clear is placed on the very edge of a detection.

// File: rtl/gfm_pkg.sv
// Shared definitions for the gate-drive timeout supervisor.
// Assumes the policy field is two bits wide and encoded as below.
package gfm_pkg;
    typedef enum logic [1:0] {
        GF_LATCH = 2'b00,
        GF_CYCLE = 2'b01,
        GF_WARN  = 2'b10,
        GF_OFF   = 2'b11
    } gf_mode_e;
endpackage

// File: rtl/gfm_chan_timer.sv
// Per-channel drive timer. Registers the PWM command, restarts on any
// command edge (when arming is allowed) and flags a timeout when the
// comparator still disagrees with the command at count == limit.
// Assumes comparator and PWM inputs are already synchronous to clk.
module gfm_chan_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pwm_i,
    input  logic          vgs_i,
    input  logic [TW-1:0] limit_i,
    input  logic          enable_i,
    input  logic          arm_ok_i,
    output logic          det_o,
    output logic          rise_o
);
    logic          cmd_q;
    logic          run_q;
    logic [TW-1:0] cnt_q;
    logic          edge_w;
    logic          start_w;
    logic          match_w;

    assign edge_w  = pwm_i ^ cmd_q;
    assign rise_o  = pwm_i & ~cmd_q;
    assign start_w = edge_w & arm_ok_i & enable_i;
    assign match_w = (vgs_i == cmd_q);
    assign det_o   = run_q & enable_i & ~match_w & (cnt_q == limit_i);

    // Track the command level and run the timeout counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= 1'b0;
            run_q <= 1'b0;
            cnt_q <= '0;
        end else begin
            cmd_q <= pwm_i;
            if (start_w) begin
                run_q <= 1'b1;
                cnt_q <= '0;
            end else if (run_q) begin
                if (!enable_i || match_w || (cnt_q == limit_i)) begin
                    run_q <= 1'b0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/gfm_chan_state.sv
// Per-channel response state: shutdown (pull-down) flag and sticky
// gate-fault flag. A new detection always outranks a clear.
// Assumes det_i is a single-cycle pulse from the channel timer.
module gfm_chan_state
    import gfm_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     det_i,
    input  logic     rise_i,
    input  gf_mode_e mode_i,
    input  logic     clr_i,
    output logic     shut_o,
    output logic     flag_o,
    output logic     arm_ok_o
);
    logic shut_q;
    logic flag_q;
    logic shut_set_w;
    logic flag_set_w;
    logic cyc_rel_w;

    assign shut_set_w = det_i & ((mode_i == GF_LATCH) | (mode_i == GF_CYCLE));
    assign flag_set_w = det_i & (mode_i != GF_OFF);
    assign cyc_rel_w  = (mode_i == GF_CYCLE) & rise_i;
    assign arm_ok_o   = ~shut_q | cyc_rel_w;
    assign shut_o     = shut_q;
    assign flag_o     = flag_q;

    // Shutdown flag: set by a protective fault, released by clear or CBC rise.
    always_ff @(posedge clk) begin
        if (!rst_n)               shut_q <= 1'b0;
        else if (shut_set_w)      shut_q <= 1'b1;
        else if (clr_i || cyc_rel_w) shut_q <= 1'b0;
    end

    // Sticky channel fault flag: set by any reported fault, released by clear.
    always_ff @(posedge clk) begin
        if (!rst_n)          flag_q <= 1'b0;
        else if (flag_set_w) flag_q <= 1'b1;
        else if (clr_i)      flag_q <= 1'b0;
    end
endmodule

// File: rtl/gfm_status.sv
// Global sticky summary bits: gate-driver summary (cycle-by-cycle faults)
// and warning (warning-policy faults). Detection outranks clear.
// Assumes det_i carries single-cycle detection pulses from all channels.
module gfm_status
    import gfm_pkg::*;
#(
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] det_i,
    input  gf_mode_e       mode_i,
    input  logic           clr_i,
    output logic           gd_o,
    output logic           warn_o
);
    logic any_w;
    logic gd_q;
    logic warn_q;

    assign any_w  = |det_i;
    assign gd_o   = gd_q;
    assign warn_o = warn_q;

    // Summary bit for cycle-by-cycle faults.
    always_ff @(posedge clk) begin
        if (!rst_n)                            gd_q <= 1'b0;
        else if (any_w && mode_i == GF_CYCLE)  gd_q <= 1'b1;
        else if (clr_i)                        gd_q <= 1'b0;
    end

    // Warning bit for report-only faults.
    always_ff @(posedge clk) begin
        if (!rst_n)                            warn_q <= 1'b0;
        else if (any_w && mode_i == GF_WARN)   warn_q <= 1'b1;
        else if (clr_i)                        warn_q <= 1'b0;
    end
endmodule

// File: rtl/gate_fault_monitor.sv
// Top of the gate-drive timeout supervisor. One timer and one response
// state per channel, plus global summary bits. Gate outputs are the PWM
// commands masked by the per-channel shutdown.
// Assumes all inputs are synchronous to clk and clr_flt_i is one cycle wide.
module gate_fault_monitor
    import gfm_pkg::*;
#(
    parameter int NCH = 4,
    parameter int TW  = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] pwm_i,
    input  logic [NCH-1:0] vgs_i,
    input  logic [TW-1:0]  drive_time_i,
    input  logic [1:0]     mode_i,
    input  logic           clr_flt_i,
    output logic [NCH-1:0] gate_o,
    output logic [NCH-1:0] pulldn_o,
    output logic           flt_o,
    output logic           warn_o,
    output logic           gd_o,
    output logic [NCH-1:0] chan_flt_o
);
    gf_mode_e       mode_w;
    logic           enable_w;
    logic [NCH-1:0] det_w;
    logic [NCH-1:0] rise_w;
    logic [NCH-1:0] arm_w;
    logic [NCH-1:0] shut_w;

    assign mode_w   = gf_mode_e'(mode_i);
    assign enable_w = (mode_w != GF_OFF);

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        gfm_chan_timer #(.TW(TW)) u_tmr (
            .clk      (clk),
            .rst_n    (rst_n),
            .pwm_i    (pwm_i[i]),
            .vgs_i    (vgs_i[i]),
            .limit_i  (drive_time_i),
            .enable_i (enable_w),
            .arm_ok_i (arm_w[i]),
            .det_o    (det_w[i]),
            .rise_o   (rise_w[i])
        );
        gfm_chan_state u_st (
            .clk      (clk),
            .rst_n    (rst_n),
            .det_i    (det_w[i]),
            .rise_i   (rise_w[i]),
            .mode_i   (mode_w),
            .clr_i    (clr_flt_i),
            .shut_o   (shut_w[i]),
            .flag_o   (chan_flt_o[i]),
            .arm_ok_o (arm_w[i])
        );
    end

    gfm_status #(.NCH(NCH)) u_stat (
        .clk    (clk),
        .rst_n  (rst_n),
        .det_i  (det_w),
        .mode_i (mode_w),
        .clr_i  (clr_flt_i),
        .gd_o   (gd_o),
        .warn_o (warn_o)
    );

    assign pulldn_o = shut_w;
    assign gate_o   = pwm_i & ~shut_w;
    assign flt_o    = |shut_w;
endmodule

// File: rtl/gate_fault_monitor_chk.sv
// Property checker for gate_fault_monitor, attached by bind.
// Observes ports plus the internal detection pulses.
module gate_fault_monitor_chk
    import gfm_pkg::*;
#(
    parameter int NCH = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic [1:0]     mode_i,
    input logic           clr_flt_i,
    input logic [NCH-1:0] det_w,
    input logic [NCH-1:0] pulldn_o,
    input logic [NCH-1:0] gate_o,
    input logic [NCH-1:0] chan_flt_o,
    input logic           gd_o,
    input logic           warn_o
);
    // R5: latched shutdowns never drop without a clear
    p_latch_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == GF_LATCH && !clr_flt_i) |=> ((pulldn_o & $past(pulldn_o)) == $past(pulldn_o)));

    // R5: a clear with no coincident detection empties all state
    p_clear_all_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_flt_i && det_w == '0) |=> (chan_flt_o == '0 && pulldn_o == '0 && !gd_o && !warn_o));

    // R7: summary bit holds until clear
    p_gd_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (gd_o && !clr_flt_i) |=> gd_o);

    // R8: warning policy never raises a pull-down
    p_warn_no_pd_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == GF_WARN) |=> ((pulldn_o & ~$past(pulldn_o)) == '0));

    // R9: off policy raises no status bit
    p_off_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == GF_OFF) |=> ((chan_flt_o & ~$past(chan_flt_o)) == '0 && !$rose(warn_o) && !$rose(gd_o)));

    // R10: a detection coinciding with clear is still recorded
    p_det_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_flt_i && det_w != '0 && mode_i != GF_OFF) |=> ((chan_flt_o & $past(det_w)) == $past(det_w)));

    // R11: no channel drives its gate while pulled down
    p_gate_mask_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ((gate_o & pulldn_o) == '0));
endmodule

bind gate_fault_monitor gate_fault_monitor_chk #(.NCH(NCH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_i     (mode_i),
    .clr_flt_i  (clr_flt_i),
    .det_w      (det_w),
    .pulldn_o   (pulldn_o),
    .gate_o     (gate_o),
    .chan_flt_o (chan_flt_o),
    .gd_o       (gd_o),
    .warn_o     (warn_o)
);

// File: tb/gate_fault_monitor_tb.sv
// Directed bench: one task per scenario, each checking its own results.
module gate_fault_monitor_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 4;
    localparam int TW  = 8;

    logic           clk = 1'b0;
    logic           rst_n;
    logic [NCH-1:0] pwm, vgs;
    logic [TW-1:0]  dtime;
    logic [1:0]     mode;
    logic           clr;
    logic [NCH-1:0] gate_o, pulldn_o, chan_flt_o;
    logic           flt_o, warn_o, gd_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gate_fault_monitor #(.NCH(NCH), .TW(TW)) u_dut (
        .clk(clk), .rst_n(rst_n), .pwm_i(pwm), .vgs_i(vgs),
        .drive_time_i(dtime), .mode_i(mode), .clr_flt_i(clr),
        .gate_o(gate_o), .pulldn_o(pulldn_o), .flt_o(flt_o),
        .warn_o(warn_o), .gd_o(gd_o), .chan_flt_o(chan_flt_o)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) tick();
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic pulse_clr();
        clr = 1'b1;
        tick();
        clr = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; pwm = '0; vgs = '0; dtime = 8'd3; mode = 2'b00; clr = 1'b0;
        ticks(3);
        rst_n = 1'b1;
        tick();
        chk("R1 pulldn", pulldn_o, 0);
        chk("R1 chan", chan_flt_o, 0);
        chk("R1 flags", {flt_o, warn_o, gd_o}, 0);
    endtask

    task automatic t_no_fault();
        dtime = 8'd3; mode = 2'b00;
        pwm[1] = 1'b1; tick();
        ticks(2);
        vgs[1] = 1'b1; ticks(10);
        chk("R2 match before limit", chan_flt_o, 0);
        pwm[1] = 1'b0; tick();
        vgs[1] = 1'b0; ticks(10);
        chk("R2 falling match", {flt_o, chan_flt_o}, 0);
    endtask

    task automatic t_latched();
        dtime = 8'd3; mode = 2'b00;
        pwm[0] = 1'b1; tick();
        ticks(3);
        chk("R2 one edge before limit", chan_flt_o, 0);
        chk("R11 gate follows", gate_o[0], 1);
        tick();
        chk("R2 fault at limit", chan_flt_o, 4'b0001);
        chk("R4 pulldn", pulldn_o, 4'b0001);
        chk("R4 flt", flt_o, 1);
        chk("R4 gd/warn clear", {gd_o, warn_o}, 0);
        chk("R11 gate masked", gate_o[0], 0);
        vgs[0] = 1'b1; pwm[0] = 1'b0; tick();
        pwm[0] = 1'b1; ticks(5);
        chk("R5 latched through edges", {flt_o, pulldn_o[0], chan_flt_o[0]}, 3'b111);
        vgs[0] = 1'b0;
        pulse_clr();
        chk("R5 cleared", {flt_o, pulldn_o, chan_flt_o}, 0);
        chk("R11 gate restored", gate_o[0], 1);
        pwm[0] = 1'b0; ticks(2);
    endtask

    task automatic t_restart();
        dtime = 8'd4; mode = 2'b00;
        pwm[1] = 1'b1; tick();
        ticks(2);
        pwm[1] = 1'b0; tick();
        pwm[1] = 1'b1; tick();
        ticks(4);
        chk("R3 restart delays fault", chan_flt_o[1], 0);
        tick();
        chk("R3 fault after restart", chan_flt_o[1], 1);
        pulse_clr();
        pwm[1] = 1'b0; ticks(2);
    endtask

    task automatic t_cycle();
        dtime = 8'd2; mode = 2'b01;
        pwm[2] = 1'b1; tick();
        ticks(3);
        chk("R6 pulldn", pulldn_o, 4'b0100);
        chk("R6 flt/gd", {flt_o, gd_o, warn_o}, 3'b110);
        chk("R6 chan", chan_flt_o, 4'b0100);
        chk("R11 gate masked cbc", gate_o[2], 0);
        pwm[2] = 1'b0; tick();
        chk("R7 fall keeps shutdown", {flt_o, pulldn_o[2]}, 2'b11);
        pwm[2] = 1'b1; vgs[2] = 1'b1; tick();
        chk("R7 rise releases", {flt_o, pulldn_o[2]}, 0);
        chk("R7 sticky kept", {gd_o, chan_flt_o[2]}, 2'b11);
        chk("R7 gate restored", gate_o[2], 1);
        ticks(5);
        chk("R7 no refault", {flt_o, pulldn_o}, 0);
        pulse_clr();
        chk("R7 clear", {gd_o, chan_flt_o}, 0);
        pwm[2] = 1'b0; vgs[2] = 1'b0; ticks(2);
    endtask

    task automatic t_warn();
        dtime = 8'd2; mode = 2'b10;
        pwm[3] = 1'b1; tick();
        ticks(3);
        chk("R8 warn/chan", {warn_o, chan_flt_o}, 5'b11000);
        chk("R8 no action", {flt_o, gd_o, pulldn_o}, 0);
        chk("R8 gate follows", gate_o[3], 1);
        ticks(4);
        chk("R8 held", warn_o, 1);
        pulse_clr();
        chk("R8 cleared", {warn_o, chan_flt_o}, 0);
        pwm[3] = 1'b0; ticks(2);
    endtask

    task automatic t_off();
        dtime = 8'd1; mode = 2'b11;
        pwm[0] = 1'b1; ticks(20);
        chk("R9 silent", {flt_o, warn_o, gd_o, pulldn_o, chan_flt_o}, 0);
        chk("R9 gate follows", gate_o[0], 1);
        pwm[0] = 1'b0; ticks(2);
        mode = 2'b00;
    endtask

    task automatic t_clr_collide();
        dtime = 8'd2; mode = 2'b00;
        pwm[1] = 1'b1; tick();
        ticks(2);
        clr = 1'b1; tick(); clr = 1'b0;
        chk("R10 fault beats clear", {flt_o, pulldn_o[1], chan_flt_o[1]}, 3'b111);
        pulse_clr();
        chk("R10 later clear", {flt_o, chan_flt_o}, 0);
        pwm[1] = 1'b0; ticks(2);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_no_fault();
        t_latched();
        t_restart();
        t_cycle();
        t_warn();
        t_off();
        t_clr_collide();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule